// File: doc/BRIEF.md
# Privileged trap-return unit

This block executes the privileged return instructions of a small RISC-V style core. Each cycle it may receive one 32-bit instruction word with a valid strobe. It decides whether the word is a machine, supervisor or user return. It checks that word against the privilege level the hart runs at. For a legal return it rewrites the machine status word and the current privilege in a single clock edge.

The unit holds the status word and the current privilege level itself. The rest of the core writes both through a load port, for example on trap entry or on a CSR write. The unit reports the updated privilege and status. It also raises a one-cycle illegal-instruction flag when a return asks for a level above the one the hart runs at.

Top module: `xret_unit`

## Requirements
- R1: A word is a return only when bits 6:0 equal 0x73 and bits 31:20 equal 0x302 (machine return), 0x102 (supervisor return) or 0x002 (user return). Any other valid word leaves the status word, the privilege and the illegal flag unchanged.
- R2: Privilege is encoded user 0, supervisor 1, machine 3. A return whose level (machine 3, supervisor 1, user 0) is numerically above the current privilege raises illegal_o for exactly one cycle and changes neither the status word nor the privilege.
- R3: A legal machine return copies status bit 7 into bit 3 and then sets bit 7 to 1.
- R4: A legal machine return takes the new privilege from status bits 12:11 (3 gives machine, 1 gives supervisor, 0 or 2 gives user) and then writes those bits to 0.
- R5: A legal supervisor return copies status bit 5 into bit 1 and sets bit 5 to 1. It takes the new privilege from bit 8 (1 gives supervisor, 0 gives user) and then writes bit 8 to 0.
- R6: A legal user return sets the privilege to user.
- R7: A legal return of any kind that executes in machine mode and ends in a lower mode clears status bit 17. A return that ends in machine mode, or that starts below machine mode, leaves bit 17 unchanged.
- R8: A return changes no status bit outside the fields named in R3 to R7.
- R9: After reset the privilege is machine, the status word is 0 and illegal_o is 0.
- R10: With ld_i high, the next edge loads ld_status_i and ld_priv_i. A return presented in the same cycle is discarded.
- R11: Every result of a return appears on the outputs from the first clock edge after the cycle in which valid_i is high. Nothing changes while valid_i and ld_i are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | insn_i holds an instruction to execute this cycle |
| insn_i | input | 32 | Instruction word |
| ld_i | input | 1 | Load status word and privilege from the core |
| ld_status_i | input | XLEN | Status word to load |
| ld_priv_i | input | 2 | Privilege to load |
| priv_o | output | 2 | Current privilege level |
| status_o | output | XLEN | Current machine status word |
| illegal_o | output | 1 | Illegal-instruction pulse for the previous cycle's return |

## Verification
Each result of a return is registered, so the new privilege, the new status word and the illegal pulse are all due on the first edge after the stimulus cycle. The bench drives a word on a falling edge and drops valid_i on the next falling edge. It samples all three outputs at that point, half a cycle after the capturing edge. One scenario samples again one cycle later, to confirm that the illegal pulse lasts a single cycle and that the state does not move further. Each scenario first preloads the state through the load port. It therefore also sees that port's effect at the edge before the return.

// File: rtl/xret_pkg.sv
package xret_pkg;
  localparam logic [1:0] PRIV_USER = 2'd0;
  localparam logic [1:0] PRIV_SUPV = 2'd1;
  localparam logic [1:0] PRIV_MACH = 2'd3;

  localparam logic [6:0]  OPC_SYSTEM = 7'h73;
  localparam logic [11:0] F12_MACH   = 12'h302;
  localparam logic [11:0] F12_SUPV   = 12'h102;
  localparam logic [11:0] F12_USER   = 12'h002;

  // status word bit positions
  localparam int unsigned B_SIE    = 1;
  localparam int unsigned B_MIE    = 3;
  localparam int unsigned B_SPIE   = 5;
  localparam int unsigned B_MPIE   = 7;
  localparam int unsigned B_SPP    = 8;
  localparam int unsigned B_MPP_LO = 11;
  localparam int unsigned B_MPP_HI = 12;
  localparam int unsigned B_MPRV   = 17;

  typedef enum logic [1:0] {
    RK_NONE = 2'd0,
    RK_USER = 2'd1,
    RK_SUPV = 2'd2,
    RK_MACH = 2'd3
  } ret_kind_e;
endpackage

// File: rtl/xret_decode.sv
module xret_decode
  import xret_pkg::*;
(
  input  logic [31:0] insn_i,
  input  logic [1:0]  cur_priv_i,
  output ret_kind_e   kind_o,
  output logic        outranks_o
);
  logic [11:0] f12;
  logic [1:0]  need;
  logic        unused_fields;

  assign f12           = insn_i[31:20];
  assign unused_fields = ^insn_i[19:7];

  always_comb begin
    kind_o = RK_NONE;
    need   = PRIV_USER;
    if (insn_i[6:0] == OPC_SYSTEM) begin
      unique case (f12)
        F12_MACH: begin kind_o = RK_MACH; need = PRIV_MACH; end
        F12_SUPV: begin kind_o = RK_SUPV; need = PRIV_SUPV; end
        F12_USER: begin kind_o = RK_USER; need = PRIV_USER; end
        default:  begin kind_o = RK_NONE; need = PRIV_USER; end
      endcase
    end
  end

  assign outranks_o = (kind_o != RK_NONE) && (cur_priv_i < need);
endmodule

// File: rtl/xret_status_calc.sv
module xret_status_calc
  import xret_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  ret_kind_e        kind_i,
  input  logic [1:0]       cur_priv_i,
  input  logic [XLEN-1:0]  status_i,
  output logic [XLEN-1:0]  status_o,
  output logic [1:0]       priv_o
);
  logic [1:0] mpp;
  assign mpp = status_i[B_MPP_HI:B_MPP_LO];

  always_comb begin
    status_o = status_i;
    priv_o   = cur_priv_i;
    unique case (kind_i)
      RK_MACH: begin
        status_o[B_MIE]  = status_i[B_MPIE];
        status_o[B_MPIE] = 1'b1;
        status_o[B_MPP_HI:B_MPP_LO] = 2'b00;
        if (mpp == PRIV_MACH)      priv_o = PRIV_MACH;
        else if (mpp == PRIV_SUPV) priv_o = PRIV_SUPV;
        else                       priv_o = PRIV_USER;
      end
      RK_SUPV: begin
        status_o[B_SIE]  = status_i[B_SPIE];
        status_o[B_SPIE] = 1'b1;
        status_o[B_SPP]  = 1'b0;
        priv_o = status_i[B_SPP] ? PRIV_SUPV : PRIV_USER;
      end
      RK_USER: priv_o = PRIV_USER;
      default: ;
    endcase
    // leaving machine mode drops the modified-privilege access bit
    if ((kind_i != RK_NONE) && (cur_priv_i == PRIV_MACH) && (priv_o != PRIV_MACH))
      status_o[B_MPRV] = 1'b0;
  end
endmodule

// File: rtl/xret_unit.sv
module xret_unit
  import xret_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic [31:0]     insn_i,
  input  logic            ld_i,
  input  logic [XLEN-1:0] ld_status_i,
  input  logic [1:0]      ld_priv_i,
  output logic [1:0]      priv_o,
  output logic [XLEN-1:0] status_o,
  output logic            illegal_o
);
  logic [XLEN-1:0] status_q, status_d, status_calc;
  logic [1:0]      priv_q, priv_d, priv_calc;
  logic            ill_q, ill_d;
  logic            state_en;
  ret_kind_e       kind;
  logic            outranks;

  xret_decode u_decode (
    .insn_i     (insn_i),
    .cur_priv_i (priv_q),
    .kind_o     (kind),
    .outranks_o (outranks)
  );

  xret_status_calc #(.XLEN(XLEN)) u_calc (
    .kind_i     (kind),
    .cur_priv_i (priv_q),
    .status_i   (status_q),
    .status_o   (status_calc),
    .priv_o     (priv_calc)
  );

  always_comb begin
    ill_d    = valid_i && outranks;
    state_en = ld_i || (valid_i && (kind != RK_NONE) && !outranks);
    if (ld_i) begin
      status_d = ld_status_i;
      priv_d   = ld_priv_i;
    end else begin
      status_d = status_calc;
      priv_d   = priv_calc;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= '0;
      priv_q   <= PRIV_MACH;
      ill_q    <= 1'b0;
    end else begin
      ill_q <= ill_d;
      if (state_en) begin
        status_q <= status_d;
        priv_q   <= priv_d;
      end
    end
  end

  assign priv_o    = priv_q;
  assign status_o  = status_q;
  assign illegal_o = ill_q;
endmodule

// File: rtl/xret_unit_chk.sv
module xret_unit_chk #(
  parameter int unsigned XLEN = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            valid_i,
  input logic [31:0]     insn_i,
  input logic            ld_i,
  input logic [1:0]      priv_o,
  input logic [XLEN-1:0] status_o,
  input logic            illegal_o
);
  logic sys, w_m, w_s, w_u, w_any, w_none;
  assign sys    = valid_i && !ld_i && (insn_i[6:0] == 7'h73);
  assign w_m    = sys && (insn_i[31:20] == 12'h302);
  assign w_s    = sys && (insn_i[31:20] == 12'h102);
  assign w_u    = sys && (insn_i[31:20] == 12'h002);
  assign w_any  = w_m || w_s || w_u;
  assign w_none = !ld_i && !w_any;

  AST_NO_EFFECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    w_none |=> ($stable(status_o) && $stable(priv_o) && !illegal_o)); // R1

  AST_OUTRANK_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (w_m && priv_o != 2'd3) |=> illegal_o); // R2

  AST_ILLEGAL_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (illegal_o && !$past(ld_i)) |-> ($stable(status_o) && $stable(priv_o))); // R2

  AST_MRET_ENABLES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (w_m && priv_o == 2'd3) |=> (status_o[3] == $past(status_o[7]) && status_o[7]
                                 && status_o[12:11] == 2'b00)); // R3

  AST_SRET_ENABLES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (w_s && priv_o != 2'd0) |=> (status_o[1] == $past(status_o[5]) && status_o[5]
                                 && !status_o[8])); // R5

  AST_URET_PRIV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    w_u |=> (priv_o == 2'd0)); // R6

  AST_MPRV_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (w_any && priv_o == 2'd3) |=> (priv_o == 2'd3 || !status_o[17])); // R7

  AST_PRIV_ENCODING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!ld_i) |-> (priv_o != 2'd2)); // R4
endmodule

bind xret_unit xret_unit_chk #(.XLEN(XLEN)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .valid_i   (valid_i),
  .insn_i    (insn_i),
  .ld_i      (ld_i),
  .priv_o    (priv_o),
  .status_o  (status_o),
  .illegal_o (illegal_o)
);

// File: tb/xret_unit_bench.sv
`timescale 1ns/1ps
module xret_unit_bench;
  localparam int XLEN = 32;
  localparam logic [31:0] W_M = 32'h3020_0073;
  localparam logic [31:0] W_S = 32'h1020_0073;
  localparam logic [31:0] W_U = 32'h0020_0073;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic            valid_i = 1'b0;
  logic [31:0]     insn_i = '0;
  logic            ld_i = 1'b0;
  logic [XLEN-1:0] ld_status_i = '0;
  logic [1:0]      ld_priv_i = '0;
  logic [1:0]      priv_o;
  logic [XLEN-1:0] status_o;
  logic            illegal_o;

  int checks = 0;
  int failures = 0;

  always #5 clk_i = ~clk_i;

  xret_unit #(.XLEN(XLEN)) u_xret_unit (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .insn_i(insn_i),
    .ld_i(ld_i), .ld_status_i(ld_status_i), .ld_priv_i(ld_priv_i),
    .priv_o(priv_o), .status_o(status_o), .illegal_o(illegal_o)
  );

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // expected outcome computed from the requirements
  function automatic void model(input logic [31:0] st, input logic [1:0] pr, input logic [31:0] w,
                                output logic [31:0] nst, output logic [1:0] npr, output logic ill);
    int k = 0;
    logic [1:0] need = 2'd0;
    nst = st; npr = pr; ill = 1'b0;
    if (w[6:0] == 7'h73) begin
      if (w[31:20] == 12'h302)      begin k = 3; need = 2'd3; end
      else if (w[31:20] == 12'h102) begin k = 2; need = 2'd1; end
      else if (w[31:20] == 12'h002) begin k = 1; need = 2'd0; end
    end
    if (k == 0) return;
    if (pr < need) begin ill = 1'b1; return; end
    if (k == 3) begin
      nst[3] = st[7]; nst[7] = 1'b1; nst[12:11] = 2'b00;
      npr = (st[12:11] == 2'd3) ? 2'd3 : (st[12:11] == 2'd1) ? 2'd1 : 2'd0;
    end else if (k == 2) begin
      nst[1] = st[5]; nst[5] = 1'b1; nst[8] = 1'b0;
      npr = st[8] ? 2'd1 : 2'd0;
    end else begin
      npr = 2'd0;
    end
    if (pr == 2'd3 && npr != 2'd3) nst[17] = 1'b0;
  endfunction

  task automatic preload(logic [31:0] st, logic [1:0] pr);
    @(negedge clk_i);
    ld_i = 1'b1; ld_status_i = st; ld_priv_i = pr;
    @(negedge clk_i);
    ld_i = 1'b0;
    check("R10", "loaded status", status_o, st);
    check("R10", "loaded priv", {30'd0, priv_o}, {30'd0, pr});
  endtask

  // one instruction in one cycle; sampled half a cycle after the capturing edge
  task automatic issue(logic [31:0] w);
    valid_i = 1'b1; insn_i = w;
    @(negedge clk_i);
    valid_i = 1'b0; insn_i = '0;
  endtask

  task automatic run_model(string req, logic [31:0] st, logic [1:0] pr, logic [31:0] w);
    logic [31:0] est; logic [1:0] epr; logic eill;
    model(st, pr, w, est, epr, eill);
    preload(st, pr);
    issue(w);
    check(req, "status", status_o, est);
    check(req, "priv", {30'd0, priv_o}, {30'd0, epr});
    check(req, "illegal", {31'd0, illegal_o}, {31'd0, eill});
  endtask

  task automatic t_reset();
    check("R9", "reset priv", {30'd0, priv_o}, 32'd3);
    check("R9", "reset status", status_o, 32'd0);
    check("R9", "reset illegal", {31'd0, illegal_o}, 32'd0);
  endtask

  task automatic t_mret_explicit();
    // MPP=3, MPIE=1: stays in machine mode, MIE picks up MPIE
    preload(32'h0000_1880, 2'd3);
    issue(W_M);
    check("R3", "mret enables", status_o, 32'h0000_0088);
    check("R4", "mret to machine", {30'd0, priv_o}, 32'd3);
    // MPP=1 with MPRV set: drops to supervisor, bit 17 cleared
    preload(32'h0002_0880, 2'd3);
    issue(W_M);
    check("R7", "mret mprv cleared", status_o, 32'h0000_0088);
    check("R4", "mret to supervisor", {30'd0, priv_o}, 32'd1);
  endtask

  task automatic t_sret_explicit();
    // S mode, SPP=1, SPIE=1, MPRV set (not touched below machine mode)
    preload(32'h0002_0120, 2'd1);
    issue(W_S);
    check("R5", "sret status", status_o, 32'h0002_0022);
    check("R7", "sret from S keeps bit17", {31'd0, status_o[17]}, 32'd1);
    check("R5", "sret priv", {30'd0, priv_o}, 32'd1);
  endtask

  task automatic t_uret_mprv();
    preload(32'hFFFF_FFFF, 2'd3);
    issue(W_U);
    check("R6", "uret priv", {30'd0, priv_o}, 32'd0);
    check("R7", "uret from machine", status_o, 32'hFFFD_FFFF);
  endtask

  task automatic t_illegal_pulse();
    preload(32'h1234_5678, 2'd1);
    issue(W_M);
    check("R2", "illegal raised", {31'd0, illegal_o}, 32'd1);
    check("R2", "status frozen", status_o, 32'h1234_5678);
    check("R2", "priv frozen", {30'd0, priv_o}, 32'd1);
    @(negedge clk_i);
    check("R2", "illegal one cycle", {31'd0, illegal_o}, 32'd0);
    check("R11", "idle no change", status_o, 32'h1234_5678);
  endtask

  task automatic t_non_returns();
    run_model("R1", 32'hA5A5_5A5A, 2'd3, 32'h3020_0033);
    run_model("R1", 32'hA5A5_5A5A, 2'd3, 32'h3030_0073);
    run_model("R1", 32'hA5A5_5A5A, 2'd0, 32'h1050_0073);
    // valid low with a return on the bus
    preload(32'h0000_1880, 2'd3);
    insn_i = W_M;
    @(negedge clk_i);
    insn_i = '0;
    check("R11", "valid low ignored", status_o, 32'h0000_1880);
  endtask

  task automatic t_load_wins();
    preload(32'h0000_1880, 2'd3);
    ld_i = 1'b1; ld_status_i = 32'h0000_0800; ld_priv_i = 2'd1;
    valid_i = 1'b1; insn_i = W_M;
    @(negedge clk_i);
    ld_i = 1'b0; valid_i = 1'b0; insn_i = '0;
    check("R10", "load beats return status", status_o, 32'h0000_0800);
    check("R10", "load beats return priv", {30'd0, priv_o}, 32'd1);
  endtask

  task automatic t_sweep();
    logic [31:0] pats [4] = '{32'hFFFF_FFFF, 32'h0000_0000, 32'hA5A5_5A5A, 32'h5A5A_A5A5};
    logic [31:0] words [3] = '{W_M, W_S, W_U};
    logic [1:0]  privs [3] = '{2'd0, 2'd1, 2'd3};
    for (int p = 0; p < 4; p++)
      for (int m = 0; m < 4; m++)
        for (int w = 0; w < 3; w++)
          for (int q = 0; q < 3; q++) begin
            logic [31:0] st;
            st = pats[p];
            st[12:11] = m[1:0];
            st[8] = m[0];
            run_model("R8", st, privs[q], words[w]);
          end
  endtask

  task automatic run_all();
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_mret_explicit();
    t_sret_explicit();
    t_uret_mprv();
    t_illegal_pulse();
    t_non_returns();
    t_load_wins();
    t_sweep();
  endtask

  initial begin
    fork
      run_all();
      begin
        #2_000_000;
        failures++;
        $display("FAIL watchdog expired actual=hung expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule